// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Interrupt Unit

This block is an eight-pin general-purpose I/O port on a simple 32-bit register bus. Only the low 8 bits of the bus carry data. Each pin is configured as an input or an output. The data window uses address bits [9:2] as a per-pin mask, so software can change single pins without a read-modify-write. External inputs pass through a two-flop synchroniser before any other logic uses them.

Each pin has its own interrupt detector. A detector senses either a level or an edge. An edge detector can fire on one chosen edge or on both edges. Edge events are latched until software clears them by writing ones to the clear register. Level status follows the synchronised input directly. A raw status and a masked status can be read back. One registered interrupt output is the OR of the masked bits.

Register map (byte offsets; the bus `addr` port is a byte address and bits [1:0] are ignored):
- 0x000–0x3FC: data window. Address bits [9:2] form the pin mask.
- 0x400: direction.
- 0x404: sense mode.
- 0x408: both-edges.
- 0x40C: polarity.
- 0x410: enable.
- 0x414: raw status.
- 0x418: masked status.
- 0x41C: clear.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, `pin_out`, `pin_oe` and `irq` are 0, and every register reads as 0.
- R2: The direction register at 0x400 drives `pin_oe`. A 1 in a bit makes that pin an output; a 0 makes it an input.
- R3: A write to an offset in 0x000–0x3FC updates only those output-direction pins whose bit in address bits [9:2] is 1.
- R4: A read of the data window returns 0 for masked-off pins. An output pin returns its driven value. An input pin returns `pin_in`, seen two clock edges after it changes.
- R5: A data write to a pin that is an input is discarded. A later switch of that pin to output drives the value that was held before the write.
- R6: When a pin's sense bit (0x404) is 1, its raw status equals the synchronised input if its polarity bit (0x40C) is 1, and its inverse if the polarity bit is 0.
- R7: When a pin's sense bit is 0 and its both-edges bit is 0, the raw status latches on a rising edge if the polarity bit is 1, or on a falling edge if the polarity bit is 0. The status stays set after the input returns.
- R8: When a pin's both-edges bit (0x408) is 1 in edge mode, either edge latches its status, whatever the polarity bit holds.
- R9: Writing 1 to a bit of 0x41C clears that latched edge status, and writing 0 leaves it unchanged. An edge that is detected in the same cycle as a clear wins, and the status stays set.
- R10: The raw status reads at 0x414. The masked status at 0x418 equals the raw status ANDed with the enable register at 0x410.
- R11: `irq` is the registered OR of the masked status bits, and it lags them by one clock.
- R12: Reads of unmapped offsets (0x420 and above) return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Bus access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data (bits [7:0] used) |
| rdata | output | 32 | Read data, valid while `sel` is high |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
An edge can be detected on a pin in the same cycle that software writes a clear to that pin's status bit. The bench provokes this case by timing a clear write so that the bus captures it on the same clock edge that latches a new synchronised edge. It then reads the raw status and expects the bit to remain set. A plain clear that follows must then drop the bit, which shows that the surviving bit came from the new edge and not from a clear that was ignored.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPIN = 8,
  parameter int AW   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic          irq
);
  localparam int MSB = NPIN + 1;

  logic [NPIN-1:0] dir_q, sense_q, both_q, pol_q, en_q, out_q;
  logic [NPIN-1:0] s1_q, s2_q, s3_q, edge_q;
  logic            irq_q;

  logic            win_data, win_ctl;
  logic [2:0]      idx;
  logic [NPIN-1:0] mask, wd, rise, fall, hit, lvl, raw, masked, clr;

  assign win_data = (addr[AW-1:MSB+1] == '0);
  assign win_ctl  = (addr[AW-1:MSB+1] == 1) && (addr[MSB:5] == '0);
  assign idx      = addr[4:2];
  assign mask     = addr[MSB:2];
  assign wd       = wdata[NPIN-1:0];

  assign rise   = s2_q & ~s3_q;
  assign fall   = ~s2_q & s3_q;
  assign hit    = both_q & (rise | fall) | ~both_q & ((pol_q & rise) | (~pol_q & fall));
  assign lvl    = ~(s2_q ^ pol_q);
  assign raw    = (sense_q & lvl) | (~sense_q & edge_q);
  assign masked = raw & en_q;
  assign clr    = (sel && wr && win_ctl && idx == 3'd7) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; sense_q <= '0; both_q <= '0; pol_q <= '0; en_q <= '0; out_q <= '0;
    end else if (sel && wr) begin
      if (win_data) out_q <= (out_q & ~(mask & dir_q)) | (wd & mask & dir_q);
      if (win_ctl) begin
        case (idx)
          3'd0: dir_q   <= wd;
          3'd1: sense_q <= wd;
          3'd2: both_q  <= wd;
          3'd3: pol_q   <= wd;
          3'd4: en_q    <= wd;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; s3_q <= '0; edge_q <= '0; irq_q <= 1'b0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      edge_q <= ~sense_q & ((edge_q & ~clr) | hit);
      irq_q  <= |masked;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel && win_data) rdata[NPIN-1:0] = ((dir_q & out_q) | (~dir_q & s2_q)) & mask;
    else if (sel && win_ctl) begin
      case (idx)
        3'd0: rdata[NPIN-1:0] = dir_q;
        3'd1: rdata[NPIN-1:0] = sense_q;
        3'd2: rdata[NPIN-1:0] = both_q;
        3'd3: rdata[NPIN-1:0] = pol_q;
        3'd4: rdata[NPIN-1:0] = en_q;
        3'd5: rdata[NPIN-1:0] = raw;
        3'd6: rdata[NPIN-1:0] = masked;
        default: ;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = irq_q;

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && win_ctl && idx == 3'd0) |=> (pin_oe == $past(wd)));

  p_input_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && win_data && dir_q == '0) |=> $stable(pin_out));

  p_edge_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr) |=> ((edge_q & $past(edge_q)) == $past(edge_q)));

  p_irq_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |$past(masked)));

  p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && !win_data && !win_ctl) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;
  logic clk = 0, rst_n = 0, sel = 0, wr = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0] pin_in = '0, pin_out, pin_oe;
  logic irq;
  int checks = 0, errors = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  gpio_irq_port dut_i (.clk, .rst_n, .sel, .wr, .addr, .wdata, .rdata,
                       .pin_in, .pin_out, .pin_oe, .irq);

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired: actual running, expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = {24'h0, d};
    @(posedge clk); #1 sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 d = rdata[7:0];
    sel = 0;
  endtask

  task automatic pins(input logic [7:0] p);
    @(negedge clk); pin_in = p;
  endtask

  task automatic settle_clear();
    repeat (4) @(posedge clk);
    bus_wr(12'h41C, 8'hFF);
  endtask

  // {mask, write data, expected pin_out}; all pins outputs, starting at 0
  localparam logic [23:0] VEC [6] = '{
    24'hFF_A5_A5, 24'h0F_00_A0, 24'hF0_FF_F0,
    24'h00_FF_F0, 24'h81_7E_70, 24'h3C_24_64 };

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq", irq, 0);
    bus_rd(12'h400, v); chk("R1 dir", v, 0);
    bus_rd(12'h410, v); chk("R1 enable", v, 0);
    bus_rd(12'h3FC, v); chk("R1 data", v, 0);

    // R2 direction
    bus_wr(12'h400, 8'hFF);
    chk("R2 pin_oe", pin_oe, 8'hFF);

    // R3 masked writes
    foreach (VEC[i]) begin
      bus_wr({2'b00, VEC[i][23:16], 2'b00}, VEC[i][15:8]);
      chk("R3 pin_out", pin_out, VEC[i][7:0]);
      bus_rd(12'h3FC, v); chk("R4 output readback", v, VEC[i][7:0]);
    end

    // R5 writes to input pins discarded
    bus_wr(12'h400, 8'h0F);
    bus_wr(12'h3FC, 8'h00);
    chk("R5 upper held", pin_out, 8'h60);
    bus_wr(12'h400, 8'hFF);
    chk("R5 after switch", pin_out, 8'h60);
    bus_wr(12'h3FC, 8'h00);

    // R4 input read with sync latency and masking
    bus_wr(12'h400, 8'h0F);
    pins(8'hA5);
    bus_rd(12'h3FC, v); chk("R4 one edge", v, 8'h00);
    bus_rd(12'h3FC, v); chk("R4 two edges", v, 8'hA0);
    bus_rd(12'h0C0, v); chk("R4 masked read", v, 8'h20);

    // interrupt setup
    bus_wr(12'h400, 8'h00);
    pins(8'h00);
    bus_wr(12'h410, 8'hFF);
    settle_clear();
    bus_rd(12'h414, v); chk("R10 raw idle", v, 0);

    // R6 level sensing
    bus_wr(12'h404, 8'h01);
    bus_wr(12'h40C, 8'h01);
    pins(8'h01);
    @(posedge clk); @(posedge clk);
    bus_rd(12'h414, v); chk("R6 high level raw", v, 8'h01);
    chk("R11 irq not yet", irq, 0);
    @(negedge clk); chk("R11 irq", irq, 1);
    bus_wr(12'h410, 8'h00);
    bus_rd(12'h418, v); chk("R10 masked off", v, 0);
    bus_rd(12'h414, v); chk("R10 raw kept", v, 8'h01);
    chk("R11 irq low", irq, 0);
    bus_wr(12'h40C, 8'h00);
    bus_rd(12'h414, v); chk("R6 low polarity", v, 8'h00);
    pins(8'h00);
    repeat (3) @(posedge clk);
    bus_rd(12'h414, v); chk("R6 low level raw", v, 8'h01);
    bus_wr(12'h404, 8'h00);
    bus_wr(12'h410, 8'hFF);
    settle_clear();

    // R7 rising edge pin1, falling edge pin2
    bus_wr(12'h40C, 8'h02);
    pins(8'h06);
    repeat (3) @(posedge clk);
    bus_rd(12'h414, v); chk("R7 rise latched", v, 8'h02);
    pins(8'h00);
    repeat (3) @(posedge clk);
    bus_rd(12'h414, v); chk("R7 fall on pin2, pin1 held", v, 8'h06);
    bus_wr(12'h41C, 8'h00);
    bus_rd(12'h414, v); chk("R9 zero write", v, 8'h06);
    bus_wr(12'h41C, 8'h02);
    bus_rd(12'h414, v); chk("R9 clear pin1", v, 8'h04);
    bus_rd(12'h418, v); chk("R10 masked", v, 8'h04);
    settle_clear();

    // R8 both edges on pin3
    bus_wr(12'h40C, 8'h00);
    bus_wr(12'h408, 8'h08);
    pins(8'h08);
    repeat (3) @(posedge clk);
    bus_rd(12'h414, v); chk("R8 rise", v, 8'h08);
    bus_wr(12'h41C, 8'h08);
    pins(8'h00);
    repeat (3) @(posedge clk);
    bus_rd(12'h414, v); chk("R8 fall", v, 8'h08);
    bus_wr(12'h41C, 8'h08);
    bus_rd(12'h414, v); chk("R9 cleared", v, 8'h00);

    // R9 edge and clear in the same cycle
    pins(8'h08);
    @(posedge clk); @(posedge clk);
    bus_wr(12'h41C, 8'h08);
    bus_rd(12'h414, v); chk("R9 set wins", v, 8'h08);
    bus_wr(12'h41C, 8'h08);
    bus_rd(12'h414, v); chk("R9 later clear", v, 8'h00);

    // R12 unmapped
    bus_rd(12'h420, v); chk("R12 read 0x420", v, 0);
    bus_rd(12'h800, v); chk("R12 read 0x800", v, 0);
    bus_wr(12'h420, 8'hFF);
    bus_wr(12'h800, 8'hFF);
    bus_rd(12'h400, v); chk("R12 dir unchanged", v, 0);
    bus_rd(12'h408, v); chk("R12 both unchanged", v, 8'h08);
    chk("R12 pin_out unchanged", pin_out, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule